// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects interrupt events from up to 32 hardware sources into a cause register and gates them through a mask register, driving a single level interrupt line. Every source owns one bit position, and that position is the same in each register of the bank. A small word-addressed register port (address, write enable, write data, read enable, read data) lets software inspect and clear causes, raise causes itself, and change the mask.

Each cause bit can be configured on its own to clear either by writing a one to it or by reading it. Beside the plain readable and writable mask, two write-only aliases let software set or clear individual mask bits without a read-modify-write. A masked view of the cause shows only the sources that can currently raise the interrupt line. Every source starts blocked after reset.

Top module: `intc_regbank`

## Requirements
- R1: After reset the cause and clear-mode registers read zero, the mask reads all ones and `irq` is low.
- R2: Registers sit at word offsets 0 clear-mode, 1 cause, 2 masked cause, 3 cause-set, 4 mask, 5 mask-set, 6 mask-clear; `rd_data` presents the addressed value on the cycle after the one in which `rd_en` is high.
- R3: A high bit of `hw_evt` sets the same cause bit at the next clock edge; `irq` is high whenever some cause bit is 1 while its mask bit is 0 (mask 1 blocks the source).
- R4: A cause bit whose clear-mode bit is 0 is cleared by writing 1 to it at offset 1; zeros written leave it, and writes at offset 1 have no effect on bits whose clear-mode bit is 1.
- R5: A cause bit whose clear-mode bit is 1 is cleared by a read of offset 1 that returns it as 1; the read returns the value before clearing.
- R6: Offset 2 reads cause AND NOT mask; clearing through it (write of 1 or read, per clear-mode bit) affects only bits that the view shows, never masked bits.
- R7: Writing 1 to a bit at offset 3 sets that cause bit; writing 0 leaves it unchanged.
- R8: Offset 4 is written and read as the whole mask; a 1 at offset 5 sets the mask bit and a 1 at offset 6 clears it, with zeros leaving the mask unchanged.
- R9: Reads of offsets 3, 5, 6 and the unused offset 7 return zero.
- R10: When a hardware event and a clear reach the same cause bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_evt | input | 32 | Per-source event pulses, sampled each cycle |
| addr | input | 3 | Register word offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt, any unmasked cause set |

## Verification
Every register update (cause, mask, clear-mode) lands on the clock edge that samples the write, read or event, and `irq` follows from those registers in the same cycle, so the bench drives on the falling edge and checks `irq` at the next falling edge. Read data is captured on the edge that samples `rd_en`, holding the value before any clear-on-read, and the bench reads it half a cycle later. A bench model updated once per driven cycle supplies the expected read values and interrupt level for both the directed corner cases and the random traffic.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    RG_MODE   = 3'd0,
    RG_CAUSE  = 3'd1,
    RG_MASKED = 3'd2,
    RG_CSET   = 3'd3,
    RG_MASK   = 3'd4,
    RG_MSET   = 3'd5,
    RG_MCLR   = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/intc_decode.sv
module intc_decode #(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              mode_wr,
  output logic              cause_wr,
  output logic              masked_wr,
  output logic              cset_wr,
  output logic              mask_wr,
  output logic              mset_wr,
  output logic              mclr_wr,
  output logic              cause_rd,
  output logic              masked_rd
);
  import intc_pkg::*;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e r);
    return a == ADDR_W'(r);
  endfunction

  always_comb begin
    mode_wr   = wr_en && hit(addr, RG_MODE);
    cause_wr  = wr_en && hit(addr, RG_CAUSE);
    masked_wr = wr_en && hit(addr, RG_MASKED);
    cset_wr   = wr_en && hit(addr, RG_CSET);
    mask_wr   = wr_en && hit(addr, RG_MASK);
    mset_wr   = wr_en && hit(addr, RG_MSET);
    mclr_wr   = wr_en && hit(addr, RG_MCLR);
    cause_rd  = rd_en && hit(addr, RG_CAUSE);
    masked_rd = rd_en && hit(addr, RG_MASKED);
  end
endmodule

// File: rtl/intc_cause_reg.sv
module intc_cause_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_evt,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] mask,
  input  logic         mode_wr,
  input  logic         cause_wr,
  input  logic         masked_wr,
  input  logic         cset_wr,
  input  logic         cause_rd,
  input  logic         masked_rd,
  output logic [N-1:0] mode,
  output logic [N-1:0] cause,
  output logic [N-1:0] set_vec,
  output logic [N-1:0] clr_vec
);
  // mode bit 0: write-one-to-clear, 1: clear-on-read
  function automatic logic [N-1:0] w1c_hits(input logic [N-1:0] d,
                                            input logic [N-1:0] m,
                                            input logic [N-1:0] vis);
    return d & ~m & vis;
  endfunction

  function automatic logic [N-1:0] cor_hits(input logic [N-1:0] c,
                                            input logic [N-1:0] m,
                                            input logic [N-1:0] vis);
    return c & m & vis;
  endfunction

  function automatic logic [N-1:0] next_cause(input logic [N-1:0] c,
                                              input logic [N-1:0] s,
                                              input logic [N-1:0] k);
    return (c & ~k) | s;   // set wins over clear
  endfunction

  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic [N-1:0] clr_w1c, clr_cor;

  always_comb begin
    clr_w1c = '0;
    clr_cor = '0;
    if (cause_wr)  clr_w1c = w1c_hits(wr_data, mode, ALL);
    if (masked_wr) clr_w1c = w1c_hits(wr_data, mode, ~mask);
    if (cause_rd)  clr_cor = cor_hits(cause, mode, ALL);
    if (masked_rd) clr_cor = cor_hits(cause, mode, ~mask);
    clr_vec = clr_w1c | clr_cor;
    set_vec = hw_evt | (cset_wr ? wr_data : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
      mode  <= '0;
    end else begin
      cause <= next_cause(cause, set_vec, clr_vec);
      if (mode_wr) mode <= wr_data;
    end
  end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wr_data,
  input  logic         mask_wr,
  input  logic         mset_wr,
  input  logic         mclr_wr,
  output logic [N-1:0] mask
);
  function automatic logic [N-1:0] next_mask(input logic [N-1:0] m,
                                             input logic [N-1:0] d,
                                             input logic wr, input logic st,
                                             input logic cl);
    logic [N-1:0] r;
    r = m;
    if (wr) r = d;
    if (st) r = r | d;
    if (cl) r = r & ~d;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else        mask <= next_mask(mask, wr_data, mask_wr, mset_wr, mclr_wr);
  end
endmodule

// File: rtl/intc_rd_port.sv
module intc_rd_port #(
  parameter int N      = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      mode,
  input  logic [N-1:0]      cause,
  input  logic [N-1:0]      mask,
  output logic [N-1:0]      rd_data
);
  import intc_pkg::*;

  logic [N-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(RG_MODE))   rd_mux = mode;
    if (addr == ADDR_W'(RG_CAUSE))  rd_mux = cause;
    if (addr == ADDR_W'(RG_MASKED)) rd_mux = cause & ~mask;
    if (addr == ADDR_W'(RG_MASK))   rd_mux = mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank #(
  parameter int N      = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      hw_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_data,
  input  logic              rd_en,
  output logic [N-1:0]      rd_data,
  output logic              irq
);
  logic mode_wr, cause_wr, masked_wr, cset_wr, mask_wr, mset_wr, mclr_wr;
  logic cause_rd, masked_rd;
  logic [N-1:0] mode_q, cause_q, mask_q, set_vec, clr_vec;

  intc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .mode_wr(mode_wr), .cause_wr(cause_wr), .masked_wr(masked_wr),
    .cset_wr(cset_wr), .mask_wr(mask_wr), .mset_wr(mset_wr),
    .mclr_wr(mclr_wr), .cause_rd(cause_rd), .masked_rd(masked_rd)
  );

  intc_cause_reg #(.N(N)) u_cause (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .wr_data(wr_data),
    .mask(mask_q), .mode_wr(mode_wr), .cause_wr(cause_wr),
    .masked_wr(masked_wr), .cset_wr(cset_wr), .cause_rd(cause_rd),
    .masked_rd(masked_rd), .mode(mode_q), .cause(cause_q),
    .set_vec(set_vec), .clr_vec(clr_vec)
  );

  intc_mask_reg #(.N(N)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .mask_wr(mask_wr),
    .mset_wr(mset_wr), .mclr_wr(mclr_wr), .mask(mask_q)
  );

  intc_rd_port #(.N(N), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .mode(mode_q), .cause(cause_q), .mask(mask_q), .rd_data(rd_data)
  );

  assign irq = |(cause_q & ~mask_q);
endmodule

// File: rtl/intc_regbank_chk.sv
module intc_regbank_chk #(
  parameter int N      = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      hw_evt,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [N-1:0]      wr_data,
  input logic              rd_en,
  input logic [N-1:0]      rd_data,
  input logic              irq,
  input logic [N-1:0]      cause,
  input logic [N-1:0]      mask,
  input logic [N-1:0]      mode
);
  // R3: every event bit is set in cause after the edge
  assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((cause & $past(hw_evt)) == $past(hw_evt)));

  // R3: fully masked bank never raises the interrupt
  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);

  // R8: mask-set alias sets the written bits
  assert_mset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(5)) |=> ((mask & $past(wr_data)) == $past(wr_data)));

  // R8: mask-clear alias clears the written bits
  assert_mclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(6)) |=> ((mask & $past(wr_data)) == '0));

  // R9: write-only offsets read back zero
  assert_wo_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == ADDR_W'(3) || addr == ADDR_W'(5) || addr == ADDR_W'(6)))
    |=> (rd_data == '0));

  // R5: read of cause clears its clear-on-read bits when no event arrives
  assert_cor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == ADDR_W'(1) && hw_evt == '0)
    |=> ((cause & $past(cause & mode)) == '0));

  // R7: cause-set writes set the written bits
  assert_cset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(3)) |=> ((cause & $past(wr_data)) == $past(wr_data)));
endmodule

bind intc_regbank intc_regbank_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
  .cause(cause_q), .mask(mask_q), .mode(mode_q)
);

// File: tb/intc_regbank_bench.sv
module intc_regbank_bench;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] hw_evt = '0, wr_data = '0, rd_data;
  logic [2:0] addr = '0;
  logic wr_en = 0, rd_en = 0, irq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] m_cause, m_mask, m_mode;

  always #4 clk = ~clk;

  intc_regbank u_intc_regbank (.clk(clk), .rst_n(rst_n), .hw_evt(hw_evt),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq));

  function automatic logic [N-1:0] expect_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return m_cause;
      3'd2: return m_cause & ~m_mask;
      3'd4: return m_mask;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one driven cycle; model updated from the requirements
  task automatic step(input string tag, input bit w, input bit r,
                      input logic [2:0] a, input logic [N-1:0] d, input logic [N-1:0] e);
    logic [N-1:0] exp_rd, clr, set, nm;
    exp_rd = expect_rd(a);
    clr = '0; set = e; nm = m_mask;
    if (w) begin
      case (a)
        3'd0: ;
        3'd1: clr |= d & ~m_mode;                 // R4
        3'd2: clr |= d & ~m_mode & ~m_mask;       // R6
        3'd3: set |= d;                           // R7
        3'd4: nm = d;                             // R8
        3'd5: nm = m_mask | d;
        3'd6: nm = m_mask & ~d;
        default: ;
      endcase
    end
    if (r && a == 3'd1) clr |= m_cause & m_mode;            // R5
    if (r && a == 3'd2) clr |= m_cause & ~m_mask & m_mode;  // R6
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wr_data = d; hw_evt = e;
    @(negedge clk);
    wr_en = 0; rd_en = 0; hw_evt = '0;
    m_cause = (m_cause & ~clr) | set;   // R10: set wins
    m_mask = nm;
    if (w && a == 3'd0) m_mode = d;
    if (r) check(tag, rd_data, exp_rd);
    check({tag, " irq R3"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_cause & ~m_mask)});
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_cause = '0; m_mask = '1; m_mode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R2 offsets
    check("R1 irq", {{(N-1){1'b0}}, irq}, '0);
    step("R1 mode", 0, 1, 3'd0, '0, '0);
    step("R1 cause", 0, 1, 3'd1, '0, '0);
    step("R1 mask", 0, 1, 3'd4, '0, '0);
    // R3 event masked then unmasked
    step("R3 evt", 0, 1, 3'd1, '0, 32'h0000_0011);
    step("R3 cause", 0, 1, 3'd1, '0, '0);
    step("R8 mclr", 1, 0, 3'd6, 32'h0000_0001, '0);
    step("R6 masked", 0, 1, 3'd2, '0, '0);
    // R4 W1C, zero no effect
    step("R4 w0", 1, 0, 3'd1, 32'h0000_0000, '0);
    step("R4 w1", 1, 0, 3'd1, 32'h0000_0001, '0);
    step("R4 rd", 0, 1, 3'd1, '0, '0);
    // R5 clear-on-read
    step("R5 mode", 1, 0, 3'd0, 32'h0000_00F0, '0);
    step("R7 cset", 1, 0, 3'd3, 32'h0000_0030, '0);
    step("R7 zero", 1, 0, 3'd3, 32'h0000_0000, '0);
    step("R4 cor ignores w1c", 1, 0, 3'd1, 32'h0000_0020, '0);
    step("R5 read", 0, 1, 3'd1, '0, '0);
    step("R5 after", 0, 1, 3'd1, '0, '0);
    // R6 masked view clears only unmasked
    step("R8 mset", 1, 0, 3'd5, 32'h0000_0300, '0);
    step("R8 mclr", 1, 0, 3'd6, 32'h0000_0100, '0);
    step("R6 set", 1, 0, 3'd3, 32'h0000_0300, '0);
    step("R6 w1", 1, 0, 3'd2, 32'h0000_0300, '0);
    step("R6 rd", 0, 1, 3'd1, '0, '0);
    // R10 event vs clear same cycle
    step("R10 w1c+evt", 1, 0, 3'd1, 32'h0000_0100, 32'h0000_0100);
    step("R10 rd", 0, 1, 3'd1, '0, '0);
    step("R10 cor+evt", 0, 1, 3'd1, '0, 32'h0000_0010);
    step("R10 rd2", 0, 1, 3'd1, '0, '0);
    // R9 write-only and unused offsets read zero
    step("R9 o3", 0, 1, 3'd3, '0, '0);
    step("R9 o5", 0, 1, 3'd5, '0, '0);
    step("R9 o6", 0, 1, 3'd6, '0, '0);
    step("R9 o7", 0, 1, 3'd7, '0, '0);
    step("R8 mask wr", 1, 0, 3'd4, 32'hA5A5_0F0F, '0);
    step("R8 mask rd", 0, 1, 3'd4, '0, '0);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      bit w, r;
      logic [N-1:0] e;
      w = ($urandom % 2) == 0;
      r = ($urandom % 3) != 0;
      e = (($urandom % 4) == 0) ? ($urandom & $urandom) : '0;
      step("R2 rand", w, r, 3'($urandom % 8), $urandom, e);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule